// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight hardware tokens that two independent agents, a left port and a right port, use to claim shared resources. The tokens are kept apart from any data storage. Each port selects a token with the low bits of its address and either writes a request or release, or reads back whether it currently holds that token. A port holds a token when it reads 0. A port does not hold it when it reads 1.

A request for a token that the other side owns is not lost. It is remembered as pending, and ownership passes to the waiting side on the same clock edge that the owner releases. The waiting side can withdraw its request by writing a release. When both ports ask for a free token in the same cycle, the left port wins and the right port's request becomes pending.

Read results go into a per-port output register and stay there until that port's next read. A write from the opposite port therefore never changes a value that has already been read. The model is fully synchronous to a single clock.

Top module: `hw_token_bank`

## Requirements
- R1: A token is chosen by address bits [2:0] alone. Address bits above bit 2 have no effect on which token is accessed.
- R2: A port acts only in a cycle where its tok_sel is 1 and its mem_en is 0. In any other cycle its write and read inputs have no effect on token state or on its rdata.
- R3: A write (wr=1) uses only wdata[0]. A value of 0 is a request and a value of 1 is a release or withdrawal. wdata bits above bit 0 are ignored.
- R4: After a port requests a free token, that port reads 0 for the token and the opposite port reads 1.
- R5: Only the owner can free a token. A write of 1 by a non-owner does not free the token. When the owner writes 1 and no request is pending, both ports then read 1.
- R6: When the non-owner writes 0, its request is held as pending, and it owns the token right after the owner's release. If the non-owner writes 1 before that release, the pending request is dropped and the release leaves the token free.
- R7: A read happens when wr=0 and rd_en=1 in an active cycle. Its result appears on rdata after the clock edge that ends the read cycle, with the token value copied onto every one of the DATA_W bits (all zeros = owned by this port, all ones = not owned).
- R8: rdata keeps its value until the same port's next read. A read in the same cycle as a write from the other port returns the value from before that write.
- R9: When both ports request a free token in the same cycle, the left port becomes the owner and the right port's request becomes pending.
- R10: After reset all tokens are free, no request is pending, and both rdata outputs are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_tok_sel | input | 1 | Left port: token access select |
| l_mem_en | input | 1 | Left port: data memory enable, must be 0 during a token access |
| l_wr | input | 1 | Left port: 1 = write, 0 = read |
| l_rd_en | input | 1 | Left port: read output enable |
| l_addr | input | ADDR_W | Left port address; bits [2:0] select the token |
| l_wdata | input | DATA_W | Left port write data; bit 0 is used |
| l_rdata | output | DATA_W | Left port registered read data |
| r_tok_sel | input | 1 | Right port: token access select |
| r_mem_en | input | 1 | Right port: data memory enable, must be 0 during a token access |
| r_wr | input | 1 | Right port: 1 = write, 0 = read |
| r_rd_en | input | 1 | Right port: read output enable |
| r_addr | input | ADDR_W | Right port address; bits [2:0] select the token |
| r_wdata | input | DATA_W | Right port write data; bit 0 is used |
| r_rdata | output | DATA_W | Right port registered read data |

## Verification
The token protocol is driven through several input patterns. A lone request separates ownership from a free token. A request against an owned token, followed by the owner's release, separates a latched pending handoff from a dropped request. A withdrawal before release shows that a cancelled request is not resurrected. Simultaneous requests on a free token confirm the left-wins rule, and a non-owner release confirms that only the owner can free a token. Further patterns change the upper address bits, set upper wdata bits against bit 0, hold mem_en high or rd_en low, and line up a read with an opposite-side write. These separate the decode, gating and read-register behaviour from the token state itself.

// File: rtl/hwtb_pkg.sv
package hwtb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_e;

    typedef struct packed {
        own_e owner;
        logic pend;     // opposite side waits for this token
    } tok_t;

    localparam tok_t TOK_FREE = '{owner: OWN_NONE, pend: 1'b0};

endpackage

// File: rtl/hwtb_port_decode.sv
module hwtb_port_decode #(
    parameter int NUM_TOKENS = 8,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 18,
    localparam int IDX_W     = $clog2(NUM_TOKENS)
) (
    input  logic                  tok_sel,
    input  logic                  mem_en,
    input  logic                  wr,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_TOKENS-1:0] req_vec,
    output logic [NUM_TOKENS-1:0] rel_vec,
    output logic                  rd_stb,
    output logic [IDX_W-1:0]      rd_idx
);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    always_comb begin
        active  = tok_sel & ~mem_en;
        idx     = addr[IDX_W-1:0];
        req_vec = '0;
        rel_vec = '0;
        if (active && wr) begin
            if (wdata[0]) begin
                rel_vec[idx] = 1'b1;
            end else begin
                req_vec[idx] = 1'b1;
            end
        end
        rd_stb = active & ~wr & rd_en;
        rd_idx = idx;
    end

endmodule

// File: rtl/hwtb_token_cell.sv
module hwtb_token_cell
    import hwtb_pkg::*;
(
    input  tok_t cur,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output tok_t nxt
);

    logic pend_d;

    always_comb begin
        nxt    = cur;
        pend_d = 1'b0;
        case (cur.owner)
            OWN_NONE: begin
                if (l_req) begin
                    nxt.owner = OWN_LEFT;
                    nxt.pend  = r_req;
                end else if (r_req) begin
                    nxt.owner = OWN_RIGHT;
                    nxt.pend  = 1'b0;
                end else begin
                    nxt = TOK_FREE;
                end
            end
            OWN_LEFT: begin
                pend_d = (cur.pend | r_req) & ~r_rel;
                if (l_rel) begin
                    nxt.owner = pend_d ? OWN_RIGHT : OWN_NONE;
                    nxt.pend  = 1'b0;
                end else begin
                    nxt.pend  = pend_d;
                end
            end
            OWN_RIGHT: begin
                pend_d = (cur.pend | l_req) & ~l_rel;
                if (r_rel) begin
                    nxt.owner = pend_d ? OWN_LEFT : OWN_NONE;
                    nxt.pend  = 1'b0;
                end else begin
                    nxt.pend  = pend_d;
                end
            end
            default: begin
                nxt = TOK_FREE;
            end
        endcase
    end

endmodule

// File: rtl/hw_token_bank.sv
module hw_token_bank
    import hwtb_pkg::*;
#(
    parameter int NUM_TOKENS = 8,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_tok_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic              l_rd_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_tok_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic              r_rd_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int IDX_W = $clog2(NUM_TOKENS);

    typedef struct packed {
        tok_t [NUM_TOKENS-1:0] tok;
        logic [DATA_W-1:0]     l_rdata;
        logic [DATA_W-1:0]     r_rdata;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_TOKENS-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
    logic                  l_rd_stb, r_rd_stb;
    logic [IDX_W-1:0]      l_rd_idx, r_rd_idx;
    tok_t [NUM_TOKENS-1:0] tok_nxt;

    hwtb_port_decode #(
        .NUM_TOKENS(NUM_TOKENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dec_l (
        .tok_sel(l_tok_sel), .mem_en(l_mem_en), .wr(l_wr), .rd_en(l_rd_en),
        .addr(l_addr), .wdata(l_wdata),
        .req_vec(l_req_vec), .rel_vec(l_rel_vec),
        .rd_stb(l_rd_stb), .rd_idx(l_rd_idx)
    );

    hwtb_port_decode #(
        .NUM_TOKENS(NUM_TOKENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dec_r (
        .tok_sel(r_tok_sel), .mem_en(r_mem_en), .wr(r_wr), .rd_en(r_rd_en),
        .addr(r_addr), .wdata(r_wdata),
        .req_vec(r_req_vec), .rel_vec(r_rel_vec),
        .rd_stb(r_rd_stb), .rd_idx(r_rd_idx)
    );

    for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_cell
        hwtb_token_cell u_cell (
            .cur  (st_q.tok[g]),
            .l_req(l_req_vec[g]),
            .l_rel(l_rel_vec[g]),
            .r_req(r_req_vec[g]),
            .r_rel(r_rel_vec[g]),
            .nxt  (tok_nxt[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.tok = tok_nxt;
        // Reads sample the state held before this cycle's writes
        if (l_rd_stb) begin
            st_d.l_rdata = {DATA_W{st_q.tok[l_rd_idx].owner != OWN_LEFT}};
        end
        if (r_rd_stb) begin
            st_d.r_rdata = {DATA_W{st_q.tok[r_rd_idx].owner != OWN_RIGHT}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tok     <= {NUM_TOKENS{TOK_FREE}};
            st_q.l_rdata <= '1;
            st_q.r_rdata <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_rdata = st_q.l_rdata;
    assign r_rdata = st_q.r_rdata;

endmodule

// File: rtl/hwtb_chk.sv
module hwtb_chk
    import hwtb_pkg::*;
#(
    parameter int NUM_TOKENS = 8,
    parameter int DATA_W     = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input tok_t [NUM_TOKENS-1:0] tok_q,
    input logic                  l_tok_sel,
    input logic                  l_mem_en,
    input logic                  l_wr,
    input logic                  l_rd_en,
    input logic                  r_tok_sel,
    input logic                  r_mem_en,
    input logic                  r_wr,
    input logic                  r_rd_en,
    input logic [NUM_TOKENS-1:0] l_req,
    input logic [NUM_TOKENS-1:0] l_rel,
    input logic [NUM_TOKENS-1:0] r_req,
    input logic [NUM_TOKENS-1:0] r_rel,
    input logic [DATA_W-1:0]     l_rdata,
    input logic [DATA_W-1:0]     r_rdata
);

    // R2
    quiet_ports_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(l_tok_sel && !l_mem_en) && !(r_tok_sel && !r_mem_en)) |=> $stable(tok_q));

    // R8
    l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_tok_sel && !l_mem_en && !l_wr && l_rd_en) |=> $stable(l_rdata));

    // R8
    r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_tok_sel && !r_mem_en && !r_wr && r_rd_en) |=> $stable(r_rdata));

    // R7
    l_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0) || (l_rdata == '1));

    // R7
    r_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdata == '0) || (r_rdata == '1));

    for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_tok
        // R10
        free_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_q[g].owner == OWN_NONE) |-> !tok_q[g].pend);

        // R6
        handoff_to_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_q[g].owner == OWN_LEFT && tok_q[g].pend && l_rel[g] && !r_rel[g])
            |=> (tok_q[g].owner == OWN_RIGHT));

        // R5
        left_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_q[g].owner == OWN_LEFT && !l_rel[g]) |=> (tok_q[g].owner == OWN_LEFT));

        // R5
        right_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_q[g].owner == OWN_RIGHT && !r_rel[g]) |=> (tok_q[g].owner == OWN_RIGHT));

        // R9
        tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_q[g].owner == OWN_NONE && l_req[g] && r_req[g])
            |=> (tok_q[g].owner == OWN_LEFT && tok_q[g].pend));
    end

endmodule

bind hw_token_bank hwtb_chk #(
    .NUM_TOKENS(NUM_TOKENS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_q    (st_q.tok),
    .l_tok_sel(l_tok_sel),
    .l_mem_en (l_mem_en),
    .l_wr     (l_wr),
    .l_rd_en  (l_rd_en),
    .r_tok_sel(r_tok_sel),
    .r_mem_en (r_mem_en),
    .r_wr     (r_wr),
    .r_rd_en  (r_rd_en),
    .l_req    (l_req_vec),
    .l_rel    (l_rel_vec),
    .r_req    (r_req_vec),
    .r_rel    (r_rel_vec),
    .l_rdata  (l_rdata),
    .r_rdata  (r_rdata)
);

// File: tb/hw_token_bank_test.sv
module hw_token_bank_test;

    localparam int NUM_TOKENS = 8;
    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 18;
    localparam int UP_W       = ADDR_W - 3;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    typedef struct packed {
        logic [1:0] lop;
        logic [2:0] la;
        logic       ld;
        logic [1:0] rop;
        logic [2:0] ra;
        logic       rd;
        logic       el;
        logic       er;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t TBL [NVEC] = '{
        '{OP_WR,   3'd0, 1'b0, OP_IDLE, 3'd0, 1'b0, 1'b0, 1'b0, 8'd4}, // R4 left takes t0
        '{OP_RD,   3'd0, 1'b0, OP_RD,   3'd0, 1'b0, 1'b0, 1'b1, 8'd4},
        '{OP_IDLE, 3'd0, 1'b0, OP_WR,   3'd0, 1'b0, 1'b0, 1'b0, 8'd6}, // R6 right pends
        '{OP_RD,   3'd0, 1'b0, OP_RD,   3'd0, 1'b0, 1'b0, 1'b1, 8'd6},
        '{OP_WR,   3'd0, 1'b1, OP_IDLE, 3'd0, 1'b0, 1'b0, 1'b0, 8'd6}, // release -> right
        '{OP_RD,   3'd0, 1'b0, OP_RD,   3'd0, 1'b0, 1'b1, 1'b0, 8'd6},
        '{OP_IDLE, 3'd0, 1'b0, OP_WR,   3'd0, 1'b1, 1'b0, 1'b0, 8'd5}, // R5 owner frees
        '{OP_RD,   3'd0, 1'b0, OP_RD,   3'd0, 1'b0, 1'b1, 1'b1, 8'd5},
        '{OP_WR,   3'd3, 1'b0, OP_WR,   3'd3, 1'b0, 1'b0, 1'b0, 8'd9}, // R9 tie
        '{OP_RD,   3'd3, 1'b0, OP_RD,   3'd3, 1'b0, 1'b0, 1'b1, 8'd9},
        '{OP_IDLE, 3'd3, 1'b0, OP_WR,   3'd3, 1'b1, 1'b0, 1'b0, 8'd6}, // withdraw
        '{OP_WR,   3'd3, 1'b1, OP_IDLE, 3'd3, 1'b0, 1'b0, 1'b0, 8'd6},
        '{OP_RD,   3'd3, 1'b0, OP_RD,   3'd3, 1'b0, 1'b1, 1'b1, 8'd6},
        '{OP_WR,   3'd7, 1'b1, OP_WR,   3'd7, 1'b0, 1'b0, 1'b0, 8'd5}, // right takes t7
        '{OP_WR,   3'd7, 1'b1, OP_IDLE, 3'd7, 1'b0, 1'b0, 1'b0, 8'd5}, // non-owner release
        '{OP_RD,   3'd7, 1'b0, OP_RD,   3'd7, 1'b0, 1'b1, 1'b0, 8'd5},
        '{OP_WR,   3'd5, 1'b0, OP_RD,   3'd5, 1'b0, 1'b0, 1'b1, 8'd8}, // R8 read vs write
        '{OP_RD,   3'd5, 1'b0, OP_RD,   3'd5, 1'b0, 1'b0, 1'b1, 8'd1}  // R1 other tokens
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_tok_sel, l_mem_en, l_wr, l_rd_en;
    logic [ADDR_W-1:0] l_addr;
    logic [DATA_W-1:0] l_wdata, l_rdata;
    logic              r_tok_sel, r_mem_en, r_wr, r_rd_en;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [DATA_W-1:0] ONES  = '1;
    localparam logic [DATA_W-1:0] ZEROS = '0;

    always #4 clk = ~clk;

    hw_token_bank #(
        .NUM_TOKENS(NUM_TOKENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .l_tok_sel(l_tok_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd_en(l_rd_en),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_tok_sel(r_tok_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd_en(r_rd_en),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        l_tok_sel = 1'b0; l_mem_en = 1'b0; l_wr = 1'b0; l_rd_en = 1'b0;
        l_addr = '0; l_wdata = '0;
        r_tok_sel = 1'b0; r_mem_en = 1'b0; r_wr = 1'b0; r_rd_en = 1'b0;
        r_addr = '0; r_wdata = '0;
    endtask

    task automatic set_l(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
        l_tok_sel = (op != OP_IDLE);
        l_wr      = (op == OP_WR);
        l_rd_en   = (op == OP_RD);
        l_addr    = a;
        l_wdata   = d;
    endtask

    task automatic set_r(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
        r_tok_sel = (op != OP_IDLE);
        r_wr      = (op == OP_WR);
        r_rd_en   = (op == OP_RD);
        r_addr    = a;
        r_wdata   = d;
    endtask

    // Inputs change 1 ns after a rising edge; outputs are sampled there too
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        #1;
        // R10: rdata reset value before any read
        chk("R10 reset l_rdata", l_rdata, ONES);
        chk("R10 reset r_rdata", r_rdata, ONES);
        rst_n = 1'b1;
        tick();

        // R10: every token reads free from both sides
        for (int t = 0; t < NUM_TOKENS; t++) begin
            idle_all();
            set_l(OP_RD, ADDR_W'(t), '0);
            set_r(OP_RD, ADDR_W'(t), '0);
            tick();
            chk("R10 l token free", l_rdata, ONES);
            chk("R10 r token free", r_rdata, ONES);
        end

        // Table walk; upper address bits vary per step (R1)
        for (int i = 0; i < NVEC; i++) begin
            logic [UP_W-1:0] up;
            up = UP_W'(i * 53 + 1);
            idle_all();
            set_l(TBL[i].lop, {up, TBL[i].la}, {{(DATA_W-1){1'b0}}, TBL[i].ld});
            set_r(TBL[i].rop, {~up, TBL[i].ra}, {{(DATA_W-1){1'b0}}, TBL[i].rd});
            tick();
            if (TBL[i].lop == OP_RD)
                chk($sformatf("R%0d table step %0d left", TBL[i].req, i),
                    l_rdata, {DATA_W{TBL[i].el}});
            if (TBL[i].rop == OP_RD)
                chk($sformatf("R%0d table step %0d right", TBL[i].req, i),
                    r_rdata, {DATA_W{TBL[i].er}});
        end
        // State now: t5 left, t7 right, others free

        // R1: same token reached through different upper address bits
        idle_all();
        set_l(OP_WR, {UP_W'(5), 3'd1}, '0);
        tick();
        idle_all();
        set_l(OP_RD, {UP_W'(0), 3'd1}, '0);
        set_r(OP_RD, {UP_W'(9), 3'd1}, '0);
        tick();
        chk("R1 alias left", l_rdata, ZEROS);
        chk("R1 alias right", r_rdata, ONES);

        // R3: only wdata[0] counts
        idle_all();
        set_l(OP_WR, 14'd2, 18'h3FFFE);
        tick();
        idle_all();
        set_l(OP_RD, 14'd2, '0);
        tick();
        chk("R3 upper ones, bit0 zero requests", l_rdata, ZEROS);
        idle_all();
        set_l(OP_WR, 14'd2, 18'h00001);
        tick();
        idle_all();
        set_l(OP_RD, 14'd2, '0);
        set_r(OP_RD, 14'd2, '0);
        tick();
        chk("R3 bit0 one releases left", l_rdata, ONES);
        chk("R3 bit0 one releases right", r_rdata, ONES);

        // R2: right takes t4 properly
        idle_all();
        set_r(OP_WR, 14'd4, '0);
        tick();
        // R2: release attempt with mem_en high is ignored
        idle_all();
        set_r(OP_WR, 14'd4, 18'h1);
        r_mem_en = 1'b1;
        tick();
        idle_all();
        set_r(OP_RD, 14'd4, '0);
        tick();
        chk("R2 mem_en write ignored", r_rdata, ZEROS);
        // R2: tok_sel low write ignored
        idle_all();
        set_r(OP_WR, 14'd4, 18'h1);
        r_tok_sel = 1'b0;
        tick();
        idle_all();
        set_r(OP_RD, 14'd4, '0);
        tick();
        chk("R2 unselected write ignored", r_rdata, ZEROS);
        // Left reads t5 (owned by left -> 0), then gated reads must not update
        idle_all();
        set_l(OP_RD, 14'd5, '0);
        tick();
        chk("R2 left reads own t5", l_rdata, ZEROS);
        idle_all();
        set_l(OP_RD, 14'd4, '0);
        l_mem_en = 1'b1;
        tick();
        chk("R2 mem_en read ignored", l_rdata, ZEROS);
        idle_all();
        set_l(OP_RD, 14'd4, '0);
        l_rd_en = 1'b0;
        tick();
        chk("R7 read needs rd_en", l_rdata, ZEROS);

        // R8: left reads free t6, then right takes t6; left value holds
        idle_all();
        set_l(OP_RD, 14'd6, '0);
        tick();
        chk("R8 left reads free t6", l_rdata, ONES);
        idle_all();
        set_r(OP_WR, 14'd6, '0);
        tick();
        idle_all();
        tick();
        chk("R8 left rdata held after other write", l_rdata, ONES);
        idle_all();
        set_r(OP_RD, 14'd6, '0);
        tick();
        chk("R8 right owns t6", r_rdata, ZEROS);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule